// File: doc/BRIEF.md
# Processing-Unit Packet Slot Manager

This block holds packets inside one tile of a grid of packet processors. Packets come in on a single valid/ready stream, either from a neighbouring tile or from the flow classifier. Each packet carries a routing tag made of several hop descriptors, and the lowest-order descriptor belongs to the current tile. A descriptor has an execute flag, an application number and a 2-bit direction. On intake the block removes that descriptor by shifting the tag right one descriptor width, with zeros filling from the top. This leaves the next tile's descriptor in the low bits. The block then stores the packet in one of two separate pools.

Packets whose execute flag is set go into a pool of processing slots. The local core claims waiting slots in arrival order. While the core holds a slot it sees that slot's packet and application number, so it can switch its context to the packet. The core then reports completion by giving the slot index. Packets whose flag is clear go into a short bypass queue. The two pools are sized and admitted independently, so a backlog of work for the core never stops traffic that only passes through. Bypass packets and completed packets leave through one of four directional outputs. These share one data bus and have separate valid and ready lines. A round-robin rule shares the outputs between the two pools, and a packet stays on the output until its chosen direction accepts it.

Top module: `pkt_slot_mgr`

## Requirements
- R1: After reset, no output direction is valid, no slot is offered for claiming, and the input is ready.
- R2: A packet whose current descriptor has execute flag 1 (descriptor bit 4 with default widths) is stored in a processing slot. The slot is then offered to the core with the descriptor's application number (descriptor bits 3:2).
- R3: A packet whose execute flag is 0 goes to the bypass queue and leaves from it in arrival order. The packet is emitted with its tag shifted right by one descriptor width (5 bits), zero-filled at the top, and its payload unchanged.
- R4: While all four processing slots are occupied, the input is not ready for an execute packet, but it still accepts a bypass packet.
- R5: While both bypass entries are occupied, the input is not ready for a bypass packet, but it still accepts an execute packet into a free processing slot.
- R6: An emitted packet keeps the same valid line and data until the ready line of its own direction is high. Ready lines on other directions have no effect.
- R7: The direction field (descriptor bits 1:0) selects the output valid line: 00 north is bit 0, 01 east is bit 1, 10 south is bit 2, 11 west/output is bit 3. At most one valid line is high at a time.
- R8: When both the bypass queue and completed slots have packets waiting, successive emitted packets alternate between the two sources.
- R9: A completion strobe that names a slot the core has not claimed has no effect, and nothing is emitted because of it.
- R10: A completed slot becomes free once its packet is emitted, and a later execute packet can use it.
- R11: Waiting processing slots are offered to the core oldest first, whatever their slot indices are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_vld | input | 1 | Incoming packet valid |
| in_pkt | input | 31 | Incoming packet: payload in the upper 16 bits, tag in the lower 15 |
| in_rdy | output | 1 | Block can take the offered packet |
| out_vld | output | 4 | Per-direction valid: N, E, S, W/output |
| out_rdy | input | 4 | Per-direction ready |
| out_pkt | output | 31 | Outgoing packet with its tag shifted |
| claim_vld | output | 1 | A waiting slot is offered to the core |
| claim_take | input | 1 | Core takes the offered slot |
| claim_slot | output | 2 | Index of the offered slot |
| claim_app | output | 2 | Application number for the offered slot |
| claim_pkt | output | 31 | Packet held in the offered slot |
| done_vld | input | 1 | Core completion strobe |
| done_slot | input | 2 | Slot that the core has completed |

## Verification
A wrong slot state can show up at the ports in three ways. A slot stuck busy makes in_rdy drop too early for execute packets. A slot freed early makes a packet appear on an output before its completion strobe, or makes it disappear. Both effects are visible within one or two cycles of the event that caused them. An error in the wait-order queue shows at once as the wrong slot index or packet on the claim outputs. An arbitration or hold fault shows as two consecutive packets from the same source, or as output data that changes while the selected direction is not ready.

// File: rtl/pkt_slot_mgr.sv
module pkt_slot_mgr #(
  parameter int NTRIP = 3,
  parameter int APP_W = 2,
  parameter int PAY_W = 16,
  parameter int NPROC = 4,
  parameter int NBYP  = 2,
  localparam int TRIP_W = APP_W + 3,
  localparam int TAG_W  = NTRIP * TRIP_W,
  localparam int PKT_W  = TAG_W + PAY_W,
  localparam int SW     = $clog2(NPROC)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_vld,
  input  logic [PKT_W-1:0] in_pkt,
  output logic             in_rdy,
  output logic [3:0]       out_vld,
  input  logic [3:0]       out_rdy,
  output logic [PKT_W-1:0] out_pkt,
  output logic             claim_vld,
  input  logic             claim_take,
  output logic [SW-1:0]    claim_slot,
  output logic [APP_W-1:0] claim_app,
  output logic [PKT_W-1:0] claim_pkt,
  input  logic             done_vld,
  input  logic [SW-1:0]    done_slot
);
  localparam int BPW = (NBYP > 1) ? $clog2(NBYP) : 1;
  localparam int BCW = $clog2(NBYP + 1);

  typedef enum logic [1:0] {S_FREE, S_WAIT, S_BUSY, S_DONE} slot_st_t;

  wire [TRIP_W-1:0] lead   = in_pkt[TRIP_W-1:0];
  wire              in_exe = lead[TRIP_W-1];
  wire [PKT_W-1:0]  in_fwd = {in_pkt[PKT_W-1:TAG_W], {TRIP_W{1'b0}}, in_pkt[TAG_W-1:TRIP_W]};

  slot_st_t         st    [NPROC];
  logic [PKT_W-1:0] s_pkt [NPROC];
  logic [1:0]       s_dir [NPROC];
  logic [APP_W-1:0] s_app [NPROC];

  logic [SW-1:0] wq [NPROC];
  logic [SW:0]   wq_cnt;

  logic [PKT_W-1:0] b_pkt [NBYP];
  logic [1:0]       b_dir [NBYP];
  logic [BPW-1:0]   b_rd, b_wr;
  logic [BCW-1:0]   b_cnt;

  logic          locked, lk_proc, pref_proc;
  logic [SW-1:0] lk_slot;

  logic          free_any, done_any, any_out, sel_proc;
  logic [SW-1:0] free_idx, done_idx, sel_slot;
  logic [1:0]    out_dir;

  always_comb begin
    free_any = 1'b0;
    free_idx = '0;
    done_any = 1'b0;
    done_idx = '0;
    for (int i = NPROC - 1; i >= 0; i--) begin
      if (st[i] == S_FREE) begin
        free_any = 1'b1;
        free_idx = SW'(i);
      end
      if (st[i] == S_DONE) begin
        done_any = 1'b1;
        done_idx = SW'(i);
      end
    end
  end

  wire b_full  = (b_cnt == BCW'(NBYP));
  wire b_any   = (b_cnt != '0);

  assign in_rdy = in_exe ? free_any : !b_full;
  wire in_fire  = in_vld && in_rdy;
  wire p_push   = in_fire && in_exe;
  wire b_push   = in_fire && !in_exe;

  assign claim_vld  = (wq_cnt != '0);
  assign claim_slot = wq[0];
  assign claim_app  = s_app[wq[0]];
  assign claim_pkt  = s_pkt[wq[0]];
  wire claim_fire   = claim_vld && claim_take;

  always_comb begin
    sel_slot = done_idx;
    if (locked) begin
      any_out  = 1'b1;
      sel_proc = lk_proc;
      sel_slot = lk_slot;
    end else begin
      any_out  = done_any || b_any;
      sel_proc = (done_any && b_any) ? pref_proc : done_any;
    end
  end

  assign out_dir = sel_proc ? s_dir[sel_slot] : b_dir[b_rd];
  assign out_pkt = sel_proc ? s_pkt[sel_slot] : b_pkt[b_rd];
  assign out_vld = any_out ? (4'b0001 << out_dir) : 4'b0000;
  wire out_fire  = |(out_vld & out_rdy);
  wire p_pop     = out_fire && sel_proc;
  wire b_pop     = out_fire && !sel_proc;

  wire [SW:0] wpos = wq_cnt - {{SW{1'b0}}, claim_fire};

  always_ff @(posedge clk) begin
    if (rst) begin
      locked    <= 1'b0;
      lk_proc   <= 1'b0;
      lk_slot   <= '0;
      pref_proc <= 1'b0;
      wq_cnt    <= '0;
      b_rd      <= '0;
      b_wr      <= '0;
      b_cnt     <= '0;
      for (int i = 0; i < NPROC; i++) begin
        st[i] <= S_FREE;
        wq[i] <= '0;
      end
    end else begin
      locked  <= any_out && !out_fire;
      lk_proc <= sel_proc;
      lk_slot <= sel_slot;
      if (out_fire) pref_proc <= !sel_proc;

      for (int i = 0; i < NPROC; i++) begin
        if (p_push && free_idx == SW'(i)) begin
          st[i]    <= S_WAIT;
          s_pkt[i] <= in_fwd;
          s_dir[i] <= lead[1:0];
          s_app[i] <= lead[TRIP_W-2:2];
        end
        if (claim_fire && wq[0] == SW'(i)) st[i] <= S_BUSY;
        if (done_vld && done_slot == SW'(i) && st[i] == S_BUSY) st[i] <= S_DONE;
        if (p_pop && sel_slot == SW'(i)) st[i] <= S_FREE;
      end

      if (claim_fire)
        for (int k = 0; k < NPROC - 1; k++) wq[k] <= wq[(k + 1) % NPROC];
      if (p_push) wq[wpos[SW-1:0]] <= free_idx;
      wq_cnt <= wq_cnt + {{SW{1'b0}}, p_push} - {{SW{1'b0}}, claim_fire};

      if (b_push) begin
        b_pkt[b_wr] <= in_fwd;
        b_dir[b_wr] <= lead[1:0];
        b_wr <= (b_wr == BPW'(NBYP - 1)) ? '0 : b_wr + 1'b1;
      end
      if (b_pop) b_rd <= (b_rd == BPW'(NBYP - 1)) ? '0 : b_rd + 1'b1;
      b_cnt <= b_cnt + BCW'(b_push) - BCW'(b_pop);
    end
  end

  p_reset_r1: assert property (@(posedge clk)
    rst |=> (out_vld == 4'b0000 && !claim_vld && in_rdy));

  p_claim_r2: assert property (@(posedge clk) disable iff (rst)
    (in_vld && in_rdy && in_exe && !claim_vld) |=> claim_vld);

  p_bypass_r3: assert property (@(posedge clk) disable iff (rst)
    (in_vld && in_rdy && !in_exe) |=> (out_vld != 4'b0000));

  p_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (out_vld != 4'b0000 && (out_vld & out_rdy) == 4'b0000)
      |=> ($stable(out_vld) && $stable(out_pkt)));

  p_onehot_r7: assert property (@(posedge clk) disable iff (rst)
    $onehot0(out_vld));
endmodule

// File: tb/tb_pkt_slot_mgr.sv
module tb_pkt_slot_mgr;
  localparam int PKT_W = 31;

  logic             clk = 0;
  logic             rst = 1;
  logic             in_vld = 0;
  logic [PKT_W-1:0] in_pkt = '0;
  logic             in_rdy;
  logic [3:0]       out_vld;
  logic [3:0]       out_rdy = 4'hF;
  logic [PKT_W-1:0] out_pkt;
  logic             claim_vld;
  logic             claim_take = 0;
  logic [1:0]       claim_slot;
  logic [1:0]       claim_app;
  logic [PKT_W-1:0] claim_pkt;
  logic             done_vld = 0;
  logic [1:0]       done_slot = '0;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;

  pkt_slot_mgr dut (
    .clk(clk), .rst(rst), .in_vld(in_vld), .in_pkt(in_pkt), .in_rdy(in_rdy),
    .out_vld(out_vld), .out_rdy(out_rdy), .out_pkt(out_pkt),
    .claim_vld(claim_vld), .claim_take(claim_take), .claim_slot(claim_slot),
    .claim_app(claim_app), .claim_pkt(claim_pkt),
    .done_vld(done_vld), .done_slot(done_slot));

  always #10 clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 20000) begin
      n_fail = n_fail + 1;
      $display("FAIL watchdog: act=%0d exp<=20000 cycles", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk + 1, n_fail);
      $finish;
    end
  end

  function automatic logic [PKT_W-1:0] mk(input logic ex, input logic [1:0] app,
      input logic [1:0] dir, input logic [9:0] rest, input logic [15:0] pay);
    return {pay, rest, ex, app, dir};
  endfunction

  function automatic logic [PKT_W-1:0] fwd(input logic [PKT_W-1:0] p);
    return {p[30:15], 5'b00000, p[14:5]};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk = n_chk + 1;
    if (!ok) begin
      n_fail = n_fail + 1;
      $display("FAIL %s: act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst = 1; in_vld = 0; claim_take = 0; done_vld = 0; out_rdy = 4'hF;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
  endtask

  task automatic send(input logic [PKT_W-1:0] p);
    in_pkt = p; in_vld = 1;
    #1;
    while (!in_rdy) begin @(negedge clk); #1; end
    @(negedge clk);
    in_vld = 0;
  endtask

  task automatic expect_out(input logic [PKT_W-1:0] p, input logic [1:0] d, input string req);
    #1;
    chk(out_vld == (4'b0001 << d), req, {28'b0, out_vld}, {28'b0, 4'b0001 << d});
    chk(out_pkt == fwd(p), req, {1'b0, out_pkt}, {1'b0, fwd(p)});
  endtask

  task automatic complete(input logic [1:0] s);
    done_vld = 1; done_slot = s;
    @(negedge clk);
    done_vld = 0;
  endtask

  initial begin
    logic [PKT_W-1:0] e [4];
    logic [PKT_W-1:0] x, y, b;
    logic [15:0] seen [4];

    // R1 reset state
    do_reset();
    in_pkt = mk(0, 0, 0, 0, 0);
    #1;
    chk(out_vld == 0, "R1", {28'b0, out_vld}, 0);
    chk(claim_vld == 0, "R1", {31'b0, claim_vld}, 0);
    chk(in_rdy == 1, "R1", {31'b0, in_rdy}, 1);

    // R3 / R7 sweep over every direction and application value on bypass
    for (int d = 0; d < 4; d++) begin
      for (int a = 0; a < 4; a++) begin
        x = mk(0, 2'(a), 2'(d), 10'(16 * a + d + 3), 16'(16'h50 + 16 * d + a));
        send(x);
        expect_out(x, 2'(d), "R3_R7");
      end
    end

    // R4 processing full, bypass still accepted
    do_reset();
    for (int i = 0; i < 4; i++) begin
      e[i] = mk(1, 2'(i), 2'(i), 10'(i + 1), 16'(16'h100 + i));
      send(e[i]);
    end
    in_pkt = mk(1, 1, 1, 0, 16'h1ff); in_vld = 1;
    #1;
    chk(in_rdy == 0, "R4", {31'b0, in_rdy}, 0);
    b = mk(0, 0, 2, 10'h2a, 16'h1ee);
    in_pkt = b;
    #1;
    chk(in_rdy == 1, "R4", {31'b0, in_rdy}, 1);
    @(negedge clk);
    in_vld = 0;
    expect_out(b, 2, "R4");

    // R9 completion for an unclaimed slot is ignored
    complete(2);
    #1;
    chk(out_vld == 0, "R9", {28'b0, out_vld}, 0);

    // R2 claim order and application number
    for (int i = 0; i < 4; i++) begin
      #1;
      chk(claim_vld && claim_slot == 2'(i), "R2", {30'b0, claim_slot}, i);
      chk(claim_app == 2'(i), "R2", {30'b0, claim_app}, i);
      chk(claim_pkt == fwd(e[i]), "R2", {1'b0, claim_pkt}, {1'b0, fwd(e[i])});
      claim_take = 1;
      @(negedge clk);
      claim_take = 0;
    end
    #1;
    chk(claim_vld == 0, "R2", {31'b0, claim_vld}, 0);

    // R6 hold until own direction ready
    out_rdy = 4'b0000;
    complete(1);
    expect_out(e[1], 1, "R6");
    out_rdy = 4'b1101;
    repeat (3) begin
      @(negedge clk);
      expect_out(e[1], 1, "R6");
    end
    out_rdy = 4'hF;
    @(negedge clk);
    #1;
    chk(out_vld == 0, "R6", {28'b0, out_vld}, 0);

    // R10 / R11 slot reuse and oldest-first claiming
    x = mk(1, 3, 0, 10'h11, 16'h200);
    send(x);
    complete(0);
    expect_out(e[0], 0, "R10");
    @(negedge clk);
    y = mk(1, 2, 3, 10'h22, 16'h201);
    send(y);
    #1;
    chk(claim_slot == 2'd1, "R11", {30'b0, claim_slot}, 1);
    chk(claim_pkt == fwd(x), "R11", {1'b0, claim_pkt}, {1'b0, fwd(x)});
    claim_take = 1;
    @(negedge clk);
    claim_take = 0;
    #1;
    chk(claim_slot == 2'd0, "R10", {30'b0, claim_slot}, 0);
    chk(claim_pkt == fwd(y), "R10", {1'b0, claim_pkt}, {1'b0, fwd(y)});

    // R5 bypass full, processing still accepted; R3 bypass order
    do_reset();
    out_rdy = 4'b0000;
    x = mk(0, 1, 0, 10'h31, 16'h401);
    y = mk(0, 2, 1, 10'h32, 16'h402);
    send(x);
    send(y);
    in_pkt = mk(0, 0, 3, 0, 16'h403); in_vld = 1;
    #1;
    chk(in_rdy == 0, "R5", {31'b0, in_rdy}, 0);
    in_pkt = mk(1, 3, 2, 0, 16'h404);
    #1;
    chk(in_rdy == 1, "R5", {31'b0, in_rdy}, 1);
    @(negedge clk);
    in_vld = 0;
    #1;
    chk(claim_vld == 1, "R5", {31'b0, claim_vld}, 1);
    expect_out(x, 0, "R5");
    out_rdy = 4'hF;
    @(negedge clk);
    expect_out(y, 1, "R3");

    // R8 round robin between the two sources
    do_reset();
    out_rdy = 4'b0000;
    send(mk(1, 1, 2, 10'h01, 16'h301));
    send(mk(1, 2, 3, 10'h02, 16'h302));
    repeat (2) begin
      claim_take = 1;
      @(negedge clk);
      claim_take = 0;
    end
    complete(0);
    complete(1);
    send(mk(0, 0, 0, 10'h03, 16'h311));
    send(mk(0, 0, 1, 10'h04, 16'h312));
    out_rdy = 4'hF;
    for (int k = 0; k < 4; k++) begin
      #1;
      chk(out_vld != 0, "R8", {28'b0, out_vld}, 1);
      seen[k] = out_pkt[30:15];
      @(negedge clk);
    end
    for (int k = 1; k < 4; k++)
      chk(seen[k][4] != seen[k-1][4], "R8", {16'b0, seen[k]}, {16'b0, seen[k-1] ^ 16'h0010});
    chk((seen[0][4] ? seen[0] : seen[1]) == 16'h311, "R3", 0, 16'h311);
    chk((seen[0][4] ? seen[1] : seen[0]) == 16'h301, "R8", 0, 16'h301);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule